// File: doc/BRIEF.md
# MDIO Management Frame Sequencer

This block is the master side of a two-wire PHY management link. A single start pulse, together with a read/write select, a PHY address, a register number and write data, launches one complete management frame on MDC and MDIO. The block makes MDC by dividing the system clock, and it drives MDIO, or releases it, one bit at a time from a fixed frame layout. When the frame is finished, it returns a one-cycle done pulse. For a read, the 16 bits captured from the PHY are held on the read-data output.

In every bit period the block first presents the data with MDC low and then raises MDC. The MDIO input is sampled at the moment MDC rises. The state machine has four states. `ST_IDLE` waits for a start. `ST_CLK_LO` is the low half of a bit and `ST_CLK_HI` is the high half. `ST_FINISH` is the single cycle in which done is asserted. The transitions are:
- idle to low on start, which latches the request;
- low to high at the end of the half-period, which samples MDIO;
- high to low at the end of the half-period on any bit except the last, which advances the bit index;
- high to finish at the end of the half-period on the last bit;
- finish to idle unconditionally.

Top module: `mdio_frame_master`

## Requirements
- R1: While reset is held, and in idle after it, mdc, mdio_oe, mdio_out and done are all 0. rd_data resets to 0.
- R2: Every frame begins with 32 bit periods in which mdio_oe is 1 and mdio_out is 1.
- R3: The 32 preamble bits are followed by a start code of 0 then 1. That is followed by an opcode: 1,0 when rd_nwr is 1 (read) and 0,1 when rd_nwr is 0 (write). All of these bits are driven with mdio_oe 1.
- R4: After the opcode, the 5-bit phy_addr is driven, then the 5-bit reg_addr, each most significant bit first, with mdio_oe 1.
- R5: A read has one turnaround bit with mdio_oe 0. Then come 16 bits with mdio_oe 0, whose MDIO values sampled at the MDC rising edges are assembled most significant bit first into rd_data. A read frame has 64 MDC pulses in total.
- R6: A write has two turnaround bits with mdio_oe 0. Then wr_data is driven most significant bit first with mdio_oe 1. A write frame has 65 MDC pulses in total. A write leaves rd_data unchanged.
- R7: The last bit of every frame is a clock pulse with mdio_oe 0. Afterwards mdc, mdio_out and mdio_oe are all 0.
- R8: Each MDC low half and each high half lasts HALF_CYC system clocks (default 4). mdio_out and mdio_oe change only while MDC is low.
- R9: done is high for exactly one cycle. It occurs 2*HALF_CYC*(number of bits) clocks after the clock edge that accepted start.
- R10: A start pulse that arrives while a frame is in progress has no effect. The frame in progress is unchanged and only one done is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a frame when the block is idle |
| rd_nwr | input | 1 | 1 selects a read, 0 selects a write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register number in the PHY |
| wr_data | input | 16 | Data for a write frame |
| rd_data | output | 16 | Data captured by the latest read frame |
| done | output | 1 | One-cycle pulse at the end of a frame |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | MDIO value seen from the line |
| mdio_out | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
If the bit index or a field offset is wrong, the bit pattern on mdio_out and mdio_oe shifts or is corrupted. This shows up within the first 46 MDC pulses, when the recorded pattern is compared with the expected one. If the divider or the state sequence is wrong, the count of MDC-high cycles or the clock on which done arrives changes, and this is seen at the end of that frame. Faults in capture order or turnaround length show up as a wrong rd_data value, or as oe asserted in a bit where the line should be released, within the same frame.

// File: rtl/mdio_seq_pkg.sv
package mdio_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_FINISH
    } mdio_state_e;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_end
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || half_end)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign half_end = run && (cnt == LAST_CNT);

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST_CNT); // R8
endmodule

// File: rtl/mdio_bit_table.sv
module mdio_bit_table #(
    parameter int PRE_LEN = 32,
    parameter int AW      = 5,
    parameter int DW      = 16,
    parameter int IW      = 7
) (
    input  logic [IW-1:0] bit_idx,
    input  logic          is_rd,
    input  logic [AW-1:0] phy,
    input  logic [AW-1:0] regn,
    input  logic [DW-1:0] wdata,
    output logic          drive_en,
    output logic          drive_val,
    output logic          capture,
    output logic          last_bit
);
    localparam int OP_POS  = PRE_LEN + 2;
    localparam int AD_POS  = OP_POS + 2;
    localparam int RG_POS  = AD_POS + AW;
    localparam int TA_POS  = RG_POS + AW;
    localparam int RDD_POS = TA_POS + 1;
    localparam int WRD_POS = TA_POS + 2;
    localparam int RD_LAST = RDD_POS + DW;
    localparam int WR_LAST = WRD_POS + DW;

    int k;

    always_comb begin
        k         = int'(bit_idx);
        drive_en  = 1'b0;
        drive_val = 1'b0;
        capture   = 1'b0;
        if (k < PRE_LEN) begin
            drive_en  = 1'b1;
            drive_val = 1'b1;
        end else if (k < OP_POS) begin
            drive_en  = 1'b1;
            drive_val = (k == PRE_LEN + 1);
        end else if (k < AD_POS) begin
            drive_en  = 1'b1;
            drive_val = is_rd ? (k == OP_POS) : (k == OP_POS + 1);
        end else if (k < RG_POS) begin
            drive_en  = 1'b1;
            drive_val = phy[AW-1-(k-AD_POS)];
        end else if (k < TA_POS) begin
            drive_en  = 1'b1;
            drive_val = regn[AW-1-(k-RG_POS)];
        end else if (is_rd) begin
            capture = (k >= RDD_POS) && (k < RD_LAST);
        end else if ((k >= WRD_POS) && (k < WR_LAST)) begin
            drive_en  = 1'b1;
            drive_val = wdata[DW-1-(k-WRD_POS)];
        end
        last_bit = is_rd ? (k == RD_LAST) : (k == WR_LAST);
    end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_seq_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int PRE_LEN  = 32,
    parameter int AW       = 5,
    parameter int DW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd_nwr,
    input  logic [AW-1:0] phy_addr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          mdc,
    input  logic          mdio_in,
    output logic          mdio_out,
    output logic          mdio_oe
);
    localparam int WR_BITS = PRE_LEN + 4 + 2*AW + 2 + DW + 1;
    localparam int IW      = $clog2(WR_BITS + 1);

    mdio_state_e   state, nxt;
    logic [IW-1:0] bit_idx;
    logic          op_rd;
    logic [AW-1:0] phy_q, reg_q;
    logic [DW-1:0] wd_q, rd_q;
    logic          half_end, in_frame;
    logic          drive_en, drive_val, capture, last_bit;

    assign in_frame = (state == ST_CLK_LO) || (state == ST_CLK_HI);

    mdio_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (in_frame),
        .half_end (half_end)
    );

    mdio_bit_table #(.PRE_LEN(PRE_LEN), .AW(AW), .DW(DW), .IW(IW)) u_table (
        .bit_idx   (bit_idx),
        .is_rd     (op_rd),
        .phy       (phy_q),
        .regn      (reg_q),
        .wdata     (wd_q),
        .drive_en  (drive_en),
        .drive_val (drive_val),
        .capture   (capture),
        .last_bit  (last_bit)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start)    nxt = ST_CLK_LO;
            ST_CLK_LO: if (half_end) nxt = ST_CLK_HI;
            ST_CLK_HI: if (half_end) nxt = last_bit ? ST_FINISH : ST_CLK_LO;
            ST_FINISH:               nxt = ST_IDLE;
            default:                 nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            op_rd   <= 1'b0;
            phy_q   <= '0;
            reg_q   <= '0;
            wd_q    <= '0;
            rd_q    <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                bit_idx <= '0;
                op_rd   <= rd_nwr;
                phy_q   <= phy_addr;
                reg_q   <= reg_addr;
                wd_q    <= wr_data;
            end
            if (state == ST_CLK_LO && half_end && capture)
                rd_q <= {rd_q[DW-2:0], mdio_in};
            if (state == ST_CLK_HI && half_end && !last_bit)
                bit_idx <= bit_idx + 1'b1;
        end
    end

    always_comb begin
        mdc      = (state == ST_CLK_HI);
        mdio_oe  = in_frame && drive_en;
        mdio_out = in_frame && drive_en && drive_val;
        done     = (state == ST_FINISH);
        rd_data  = rd_q;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_IDLE) |-> (!mdc && !mdio_oe && !mdio_out && !done)); // R1
    AST_CAPTURE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (capture && in_frame) |-> !mdio_oe); // R5
    AST_LAST_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (last_bit && mdc) |-> !mdio_oe); // R7
    AST_HIGH_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe))); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n) (in_frame && start) |=> ($stable(phy_q) && $stable(op_rd) && $stable(wd_q))); // R10
endmodule

// File: tb/mdio_frame_master_bench.sv
module mdio_frame_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rd_nwr = 1'b0;
    logic [4:0] phy_addr = '0;
    logic [4:0] reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic done, mdc, mdio_out, mdio_oe;
    logic mdio_in = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    int rise_cnt = 0;
    int hi_cnt = 0;
    int done_cnt = 0;
    bit cur_rd = 0;
    logic [15:0] resp_q = '0;
    logic rec_oe [0:69];
    logic rec_d  [0:69];
    logic [15:0] last_read = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_frame_master #(.HALF_CYC(H)) u_mdio_frame_master (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .done(done), .mdc(mdc), .mdio_in(mdio_in),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // PHY model: records each bit at the MDC rise and supplies read data
    initial forever begin
        @(posedge mdc);
        if (rise_cnt < 70) begin
            rec_oe[rise_cnt] = mdio_oe;
            rec_d[rise_cnt]  = mdio_out;
        end
        rise_cnt++;
        if (cur_rd && rise_cnt >= 47 && rise_cnt <= 62)
            mdio_in = resp_q[15-(rise_cnt-47)];
        else
            mdio_in = 1'b0;
    end

    initial forever begin
        @(negedge clk);
        if (mdc) hi_cnt++;
        if (done) done_cnt++;
    end

    function automatic int region_err(input logic [64:0] eo, input logic [64:0] ed, input int n, input int lo, input int hi);
        int e = 0;
        for (int k = lo; k <= hi; k++)
            if (rec_oe[k] !== eo[n-1-k] || rec_d[k] !== ed[n-1-k]) e++;
        return e;
    endfunction

    task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] rsp, input bit poke_busy);
        int n = rd ? 64 : 65;
        int cyc = 0;
        logic [64:0] eo, ed;
        if (rd) begin
            ed = {1'b0, 32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra, 1'b0, 16'h0000, 1'b0};
            eo = {1'b0, {46{1'b1}}, 18'b0};
        end else begin
            ed = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b00, wd, 1'b0};
            eo = {{46{1'b1}}, 2'b00, {16{1'b1}}, 1'b0};
        end
        cur_rd = rd; resp_q = rsp;
        rise_cnt = 0; hi_cnt = 0; done_cnt = 0;
        @(negedge clk);
        start = 1'b1; rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (poke_busy && cyc == 100) begin
                start = 1'b1; rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
            end else if (poke_busy && cyc == 101) begin
                start = 1'b0;
            end
        end
        check(cyc == 2*H*n, "R9", "done latency", cyc, 2*H*n);
        check(rise_cnt == n, rd ? "R5" : "R6", "mdc pulse count", rise_cnt, n);
        check(hi_cnt == n*H, "R8", "mdc high cycles", hi_cnt, n*H);
        check(region_err(eo, ed, n, 0, 31) == 0, "R2", "preamble mismatches", region_err(eo, ed, n, 0, 31), 0);
        check(region_err(eo, ed, n, 32, 35) == 0, "R3", "start/opcode mismatches", region_err(eo, ed, n, 32, 35), 0);
        check(region_err(eo, ed, n, 36, 45) == 0, "R4", "address mismatches", region_err(eo, ed, n, 36, 45), 0);
        check(region_err(eo, ed, n, 46, n-2) == 0, rd ? "R5" : "R6", "turnaround/data mismatches",
              region_err(eo, ed, n, 46, n-2), 0);
        check(rec_oe[n-1] === 1'b0, "R7", "final bit oe", int'(rec_oe[n-1]), 0);
        @(negedge clk);
        check(done == 1'b0, "R9", "done width", int'(done), 0);
        check(!mdc && !mdio_oe && !mdio_out, "R7", "idle after frame", {mdc, mdio_oe, mdio_out}, 0);
        repeat (20) @(negedge clk);
        check(done_cnt == 1, poke_busy ? "R10" : "R9", "done count", done_cnt, 1);
        if (rd) begin
            check(rd_data == rsp, "R5", "read data", rd_data, rsp);
            last_read = rsp;
        end else begin
            check(rd_data == last_read, "R6", "rd_data kept on write", rd_data, last_read);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!mdc && !mdio_oe && !mdio_out && !done, "R1", "outputs in reset", {mdc, mdio_oe, mdio_out, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!mdc && !mdio_oe && !mdio_out && !done, "R1", "idle outputs", {mdc, mdio_oe, mdio_out, done}, 0);
        check(rd_data == 16'h0, "R1", "rd_data reset", rd_data, 0);
    endtask

    task automatic test_write_basic();   run_frame(1'b0, 5'h1B, 5'h04, 16'hA5C3, 16'h0, 1'b0); endtask // R6
    task automatic test_read_low_addr(); run_frame(1'b1, 5'h00, 5'h1F, 16'h0, 16'h9E61, 1'b0); endtask // R5
    task automatic test_read_high_addr();run_frame(1'b1, 5'h1F, 5'h00, 16'h0, 16'h0001, 1'b0); endtask // R4
    task automatic test_write_extremes();
        run_frame(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0, 1'b0);
        run_frame(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0, 1'b0);
    endtask
    task automatic test_busy_start();    run_frame(1'b0, 5'h05, 5'h11, 16'h3C0F, 16'h0, 1'b1); endtask // R10

    initial begin
        test_reset();
        test_write_basic();
        test_read_low_addr();
        test_read_high_addr();
        test_write_extremes();
        test_busy_start();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule